// File: doc/BRIEF.md
# I/O Window Decoder with Counter Overlay and Edge Interrupt

This block sits on an 8-bit ISA-style I/O bus and claims a 16-byte window whose position is set by a 6-bit base value compared against address bits 9:4. Inside the window it raises select lines for two parallel port groups and for a counter/timer. The counter/timer has no addresses of its own. It borrows the four offsets of parallel group 0 whenever an overlay flag is set. A write of any value to offset Dh sets that flag, and a read of the same offset clears it. Offsets 8h to Ch, and reads of Dh and Fh, fall to the decoder itself, which answers with FFh and changes nothing.

The block also turns an external interrupt bit into an IRQ line. The bit is taken from port C bit 3 of group 0. It passes through a two-stage synchroniser, and its rising edge sets a sticky latch. IRQ is driven while the latch is set and the enable strap is active. A write to offset Fh clears the latch.

A byte register at offset Eh drives the output-buffer enable through its bit 0 when test mode is selected. Otherwise the buffers are held enabled.

All outputs are registered. The strobes and address are sampled on a clock edge, and the matching outputs appear after that edge. They stay valid for as long as the strobe is held. State changes only on the first cycle of a strobe.

Top module: `iowin_decoder`

## Requirements
- R1: An access asserts a select or `rdata_oe` only when `bus_addr[9:4]` equals `base_sel`; any other address leaves every select and `rdata_oe` low.
- R2: With the overlay flag clear, offsets 0h–3h assert `sel_grp0` alone, one cycle after the strobe is sampled; at most one select is high at any time.
- R3: Offsets 4h–7h assert `sel_grp1` whatever the overlay flag holds.
- R4: A write of any data to offset Dh sets the overlay flag; afterwards offsets 0h–3h assert `sel_ctr` instead of `sel_grp0`; the access to Dh asserts no select.
- R5: A read of offset Dh clears the overlay flag, and group 0 is visible again.
- R6: Synchronous reset clears the overlay flag, the Eh register (reads back 00h), the interrupt latch and `irq`, every select, `rdata_oe` and `buf_en`.
- R7: A rising edge of `irq_src` sets the interrupt latch; `irq` rises on the fourth clock edge after the edge is applied (two sync stages, edge detect, output register) and stays high.
- R8: A write to offset Fh clears the latch, so `irq` falls within two edges. With `int_en` low a rising edge still sets the latch but `irq` stays low, and `irq` rises one edge after `int_en` goes high.
- R9: A write to offset Eh stores the whole data byte, and a read of Eh returns it with `rdata_oe` high; `buf_en` follows bit 0 of that byte when `test_mode` is 1 and is 1 when `test_mode` is 0.
- R10: Reads of offsets 8h–Ch, Dh and Fh drive `rdata` = FFh with `rdata_oe` high; writes to 8h–Ch change nothing and assert no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | I/O address |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_wdata | input | 8 | Write data |
| base_sel | input | 6 | Window base, compared against address bits 9:4 |
| int_en | input | 1 | Interrupt enable strap |
| test_mode | input | 1 | Take the buffer enable from the Eh register |
| irq_src | input | 1 | Asynchronous interrupt source (group 0 port C bit 3) |
| sel_grp0 | output | 1 | Parallel group 0 select |
| sel_grp1 | output | 1 | Parallel group 1 select |
| sel_ctr | output | 1 | Counter/timer select |
| rdata | output | 8 | Read data driven by the decoder |
| rdata_oe | output | 1 | Decoder drives the read data |
| irq | output | 1 | Interrupt request |
| buf_en | output | 1 | Output buffer enable |

## Verification
The bench builds the block with its default widths: a 10-bit address, a 4-bit offset and 8-bit data. With these widths the base has only 64 values and the window only 16 offsets, so every base is swept against every offset, once as a read and once as a write. Each base is also tried against an address outside its window. A bench model of the overlay flag and the Eh register moves along with the design through the sweep, so overlay swaps and buffer-enable changes are checked after every possible base. Directed sequences then cover the exact interrupt latency, clearing of the latch, and gating by the enable strap.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_GRP0,
    TGT_GRP1,
    TGT_CTR,
    TGT_OVL,
    TGT_BUF,
    TGT_CLR,
    TGT_UNDEC
  } tgt_e;

  localparam int GRP_SPAN = 4;
  localparam int OFF_OVL  = 13;
  localparam int OFF_BUF  = 14;
  localparam int OFF_CLR  = 15;
endpackage

// File: rtl/iowin_window_match.sv
module iowin_window_match #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 4,
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  assign hit = (addr[ADDR_W-1:OFF_W] == base);
  assign off = addr[OFF_W-1:0];
endmodule

// File: rtl/iowin_target_decode.sv
module iowin_target_decode
  import iowin_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             hit,
  input  logic [OFF_W-1:0] off,
  input  logic             ovl,
  output tgt_e             tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (hit) begin
      if (off < OFF_W'(GRP_SPAN))
        tgt = ovl ? TGT_CTR : TGT_GRP0;
      else if (off < OFF_W'(2 * GRP_SPAN))
        tgt = TGT_GRP1;
      else if (off == OFF_W'(OFF_OVL))
        tgt = TGT_OVL;
      else if (off == OFF_W'(OFF_BUF))
        tgt = TGT_BUF;
      else if (off == OFF_W'(OFF_CLR))
        tgt = TGT_CLR;
      else
        tgt = TGT_UNDEC;
    end
  end
endmodule

// File: rtl/iowin_irq_latch.sv
module iowin_irq_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic clr,
  input  logic en,
  output logic irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   rise;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= src;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], src};
      end
    end
  endgenerate

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (rise)     pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      irq <= pend_q & en;
    end
  end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int OFF_W       = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BASE_W-1:0] base_sel,
  input  logic              int_en,
  input  logic              test_mode,
  input  logic              irq_src,
  output logic              sel_grp0,
  output logic              sel_grp1,
  output logic              sel_ctr,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              irq,
  output logic              buf_en
);
  logic             hit;
  logic [OFF_W-1:0] off;
  tgt_e             tgt;
  logic             strobe;
  logic             stb_d;
  logic             start;
  logic             ovl_q;
  logic [DATA_W-1:0] bufreg_q;
  logic             clr_pulse;
  logic             owns_rd;

  iowin_window_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .addr (bus_addr),
    .base (base_sel),
    .hit  (hit),
    .off  (off)
  );

  iowin_target_decode #(.OFF_W(OFF_W)) u_decode (
    .hit (hit),
    .off (off),
    .ovl (ovl_q),
    .tgt (tgt)
  );

  assign strobe    = bus_rd | bus_wr;
  assign start     = strobe & ~stb_d;
  assign clr_pulse = start & bus_wr & (tgt == TGT_CLR);
  assign owns_rd   = (tgt == TGT_BUF) | (tgt == TGT_CLR) |
                     (tgt == TGT_OVL) | (tgt == TGT_UNDEC);

  iowin_irq_latch #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk (clk),
    .rst (rst),
    .src (irq_src),
    .clr (clr_pulse),
    .en  (int_en),
    .irq (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d    <= 1'b0;
      ovl_q    <= 1'b0;
      bufreg_q <= '0;
    end else begin
      stb_d <= strobe;
      if (start && tgt == TGT_OVL)
        ovl_q <= bus_wr;
      if (start && bus_wr && tgt == TGT_BUF)
        bufreg_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_grp0 <= 1'b0;
      sel_grp1 <= 1'b0;
      sel_ctr  <= 1'b0;
      rdata_oe <= 1'b0;
      rdata    <= '1;
      buf_en   <= 1'b0;
    end else begin
      sel_grp0 <= strobe & (tgt == TGT_GRP0);
      sel_grp1 <= strobe & (tgt == TGT_GRP1);
      sel_ctr  <= strobe & (tgt == TGT_CTR);
      rdata_oe <= bus_rd & owns_rd;
      rdata    <= (bus_rd && tgt == TGT_BUF) ? bufreg_q : '1;
      buf_en   <= test_mode ? bufreg_q[0] : 1'b1;
    end
  end
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8,
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [BASE_W-1:0] base_sel,
  input logic              int_en,
  input logic              test_mode,
  input logic              sel_grp0,
  input logic              sel_grp1,
  input logic              sel_ctr,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              irq,
  input logic              buf_en,
  input logic              ovl_q
);
  logic             in_win;
  logic [OFF_W-1:0] offs;
  logic             stb;
  assign in_win = (bus_addr[ADDR_W-1:OFF_W] == base_sel);
  assign offs   = bus_addr[OFF_W-1:0];
  assign stb    = bus_rd | bus_wr;

  p_window_r1: assert property (@(posedge clk) disable iff (rst)
    (sel_grp0 | sel_grp1 | sel_ctr | rdata_oe) |-> $past(in_win));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_grp0, sel_grp1, sel_ctr}));

  p_grp1_r3: assert property (@(posedge clk) disable iff (rst)
    sel_grp1 |-> ($past(offs) >= OFF_W'(4) && $past(offs) < OFF_W'(8)));

  p_ctr_r4: assert property (@(posedge clk) disable iff (rst)
    sel_ctr |-> $past(ovl_q));

  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (stb && !$past(stb) && bus_wr && in_win && offs == OFF_W'(13)) |=> ovl_q);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (stb && !$past(stb) && !bus_wr && bus_rd && in_win && offs == OFF_W'(13)) |=> !ovl_q);

  p_grp0_r5: assert property (@(posedge clk) disable iff (rst)
    sel_grp0 |-> !$past(ovl_q));

  p_irq_en_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(int_en));

  p_buf_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(test_mode) && !$past(rst)) |-> buf_en);

  p_undec_r10: assert property (@(posedge clk) disable iff (rst)
    (rdata_oe && rdata != '1) |-> $past(offs) == OFF_W'(14));
endmodule

bind iowin_decoder iowin_decoder_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .base_sel(base_sel), .int_en(int_en), .test_mode(test_mode),
  .sel_grp0(sel_grp0), .sel_grp1(sel_grp1), .sel_ctr(sel_ctr),
  .rdata(rdata), .rdata_oe(rdata_oe), .irq(irq), .buf_en(buf_en), .ovl_q(ovl_q)
);

// File: tb/iowin_decoder_tb.sv
`timescale 1ns/1ps
module iowin_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [5:0] base_sel = '0;
  logic       int_en = 1'b0;
  logic       test_mode = 1'b0;
  logic       irq_src = 1'b0;
  logic       sel_grp0, sel_grp1, sel_ctr, rdata_oe, irq, buf_en;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit m_ovl = 1'b0;
  logic [7:0] m_buf = 8'h00;

  always #4 clk = ~clk;

  iowin_decoder u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .base_sel(base_sel), .int_en(int_en),
    .test_mode(test_mode), .irq_src(irq_src), .sel_grp0(sel_grp0),
    .sel_grp1(sel_grp1), .sel_ctr(sel_ctr), .rdata(rdata), .rdata_oe(rdata_oe),
    .irq(irq), .buf_en(buf_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One access: strobe sampled at one posedge, outputs checked at the next negedge.
  task automatic acc(input logic [9:0] a, input bit w, input logic [7:0] d);
    bit hit;
    int off;
    hit = (a[9:4] == base_sel);
    off = int'(a[3:0]);
    bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d;
    @(negedge clk);
    chk(hit ? "R2" : "R1", {31'd0, sel_grp0}, {31'd0, hit && off < 4 && !m_ovl});
    chk("R3", {31'd0, sel_grp1}, {31'd0, hit && off >= 4 && off < 8});
    chk("R4", {31'd0, sel_ctr}, {31'd0, hit && off < 4 && m_ovl});
    chk("R10", {31'd0, rdata_oe}, {31'd0, !w && hit && off >= 8});
    chk("R9", {24'd0, rdata}, {24'd0, (!w && hit && off == 14) ? m_buf : 8'hFF});
    if (hit && off == 13) m_ovl = w;
    if (hit && w && off == 14) m_buf = d;
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    chk("R9", {31'd0, buf_en}, {31'd0, test_mode ? m_buf[0] : 1'b1});
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    edges(3);
    // R6: reset state
    chk("R6", {31'd0, sel_grp0 | sel_grp1 | sel_ctr}, 32'd0);
    chk("R6", {31'd0, rdata_oe}, 32'd0);
    chk("R6", {31'd0, irq}, 32'd0);
    chk("R6", {31'd0, buf_en}, 32'd0);
    rst = 1'b0;
    edges(1);
    chk("R9", {31'd0, buf_en}, 32'd1);
    acc(10'h00E, 1'b0, 8'h00);   // R6: Eh reads 00h after reset
    acc(10'h000, 1'b0, 8'h00);   // R6: overlay clear, group 0 visible

    // Exhaustive sweep over base, offset and direction
    test_mode = 1'b1;
    for (int b = 0; b < 64; b++) begin
      base_sel = 6'(b);
      for (int o = 0; o < 16; o++) begin
        for (int w = 0; w < 2; w++) begin
          acc({6'(b), 4'(o)}, w[0], 8'((b * 16 + o) ^ 8'h5A));
          acc({6'(b) ^ 6'h21, 4'(o)}, w[0], 8'h3C);   // R1: outside window
        end
      end
    end

    // R4/R5: overlay swap round trip at one base
    base_sel = 6'h2A;
    acc(10'h2AD, 1'b1, 8'h00);
    acc(10'h2A2, 1'b0, 8'h00);
    acc(10'h2AD, 1'b0, 8'h00);
    acc(10'h2A1, 1'b1, 8'h00);
    test_mode = 1'b0;
    edges(1);
    chk("R9", {31'd0, buf_en}, 32'd1);

    // R7: rising edge, exact latency
    int_en = 1'b1;
    irq_src = 1'b1;
    edges(3);
    chk("R7", {31'd0, irq}, 32'd0);
    edges(1);
    chk("R7", {31'd0, irq}, 32'd1);
    irq_src = 1'b0;
    edges(6);
    chk("R7", {31'd0, irq}, 32'd1);
    // R8: clear
    acc(10'h2AF, 1'b1, 8'h77);
    chk("R8", {31'd0, irq}, 32'd0);
    // R8: enable gating keeps the latch
    int_en = 1'b0;
    irq_src = 1'b1;
    edges(6);
    chk("R8", {31'd0, irq}, 32'd0);
    int_en = 1'b1;
    edges(1);
    chk("R8", {31'd0, irq}, 32'd1);
    acc(10'h2AF, 1'b1, 8'h00);
    chk("R8", {31'd0, irq}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule